// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block turns one virtual address into a leaf page-table entry. A request gives it a virtual address, a table root address, a translation-enable flag and the size of installed memory. The walker then reads page-table entries one level at a time through a single-outstanding memory read port. It finishes by pulsing `done` with either a usable leaf entry or an all-zero entry, which the caller treats as a fault.

A leaf entry can turn up above the lowest level. In that case the walker returns it as a page-sized leaf: it ORs the virtual page number bits that no level has consumed yet into the entry's PPN field. A TLB that holds only page-sized entries can then store the result as it is. The walker evaluates no permissions, holds no TLB and does not implement the memory.

Entry layout: bit 0 is the table (descend) bit, bit 1 is the leaf/valid bit, bits 7:2 are permission bits, and the PPN field starts at bit `PPN_LSB` (13). The defaults are 3 levels, 10 index bits per level, 8 KiB pages (page shift 13), a 43-bit virtual address and 8-byte entries.

Top module: `ptw_walker`

## Requirements
- R1: A virtual address that differs from its own sign extension from bit 42 produces a zero result and issues no memory read.
- R2: With `vm_en` low, a canonical address below `mem_size` returns an identity entry: bit 1 set, bits 7:2 all set, and PPN equal to the address shifted right by 13. Any other address returns zero. No memory is read.
- R3: The walk starts at `ptbr` at the top level. The index at level L is the virtual address shifted right by 13 + 10·L, masked to 10 bits. The entry is read at base + index·8.
- R4: An entry address at or above `mem_size` ends the walk with zero, and no read is issued for it.
- R5: A fetched entry with bit 1 set ends the walk. The virtual page number bits below the current level (the low 10·L bits of address >> 13) are ORed into its PPN field before it is returned.
- R6: A leaf is returned only if (merged PPN << 13) + (address mod 8192) is below `mem_size`. Otherwise the result is zero.
- R7: An entry with bit 1 clear and bit 0 clear ends the walk with zero. With bit 0 set, the next base is PPN << 13 and the walk goes down one level.
- R8: A table entry at level 0 uses up the levels and produces zero.
- R9: `mem_req` is a one-cycle pulse. A new read is never issued before `mem_rvalid` has answered the last one, whatever the latency. Each level visited costs exactly one read.
- R10: `done` is high for one cycle and carries the result on `pte`. A new `start` is accepted whenever `busy` is low, including the cycle in which `done` is high.
- R11: After reset `busy`, `done` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (taken when not busy) |
| vaddr | input | 64 | Virtual address to translate |
| vm_en | input | 1 | Translation enable; low selects the identity mapping |
| ptbr | input | 64 | Byte address of the top-level table |
| mem_size | input | 64 | Installed memory size in bytes; held stable during a walk |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle result strobe |
| pte | output | 64 | Result entry, valid while done is high |
| mem_req | output | 1 | Read request pulse |
| mem_addr | output | 64 | Read byte address, valid with mem_req |
| mem_rvalid | input | 1 | Read data strobe |
| mem_rdata | input | 64 | Read data |

## Verification
The result strobe of one walk and the acceptance of the next walk's `start` can fall in the same cycle. The bench raises `start` for the following request at the very sampling point where it sees `done`, so every walk in the run is launched back to back. The short walks (non-canonical or identity) finish one cycle after acceptance, and a dropped or late-taken start there would show up as a missing strobe or a wrong result. Each result and its read count are compared with a bench model. The model replays the same table contents in memory, and the memory answers after random latencies.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    // entry bit positions shared by the walker and its helpers
    localparam int TBL_BIT   = 0;
    localparam int LEAF_BIT  = 1;
    localparam logic [63:0] PERM_ALL = 64'h0000_0000_0000_00FC;

    typedef enum logic [1:0] {
        W_IDLE = 2'd0,
        W_REQ  = 2'd1,
        W_WAIT = 2'd2
    } walk_state_e;
endpackage

// File: rtl/ptw_canon.sv
module ptw_canon #(
    parameter int XLEN = 64,
    parameter int VA_W = 43
) (
    input  logic [XLEN-1:0] va,
    output logic            ok
);
    localparam int TOP_N = XLEN - VA_W + 1;

    logic [TOP_N-1:0] upper;
    always_comb begin
        upper = va[XLEN-1:VA_W-1];
        ok    = (&upper) || !(|upper);
    end
endmodule

// File: rtl/ptw_index.sv
module ptw_index #(
    parameter int XLEN      = 64,
    parameter int LVL_W     = 2,
    parameter int IDX_W     = 10,
    parameter int PG_SHIFT  = 13,
    parameter int PTE_BYTES = 8
) (
    input  logic [XLEN-1:0]  va,
    input  logic [XLEN-1:0]  base,
    input  logic [LVL_W-1:0] lvl,
    input  logic [XLEN-1:0]  mem_size,
    output logic [XLEN-1:0]  ent_addr,
    output logic             in_mem
);
    localparam int ENT_SH = $clog2(PTE_BYTES);
    localparam logic [XLEN-1:0] IDX_MASK = (XLEN'(1) << IDX_W) - XLEN'(1);

    logic [XLEN-1:0] idx;
    int              sh;

    always_comb begin
        sh       = PG_SHIFT + int'(lvl) * IDX_W;
        idx      = (va >> sh) & IDX_MASK;
        ent_addr = base + (idx << ENT_SH);
        in_mem   = ent_addr < mem_size;
    end
endmodule

// File: rtl/ptw_leaf.sv
module ptw_leaf #(
    parameter int XLEN     = 64,
    parameter int LVL_W    = 2,
    parameter int IDX_W    = 10,
    parameter int PG_SHIFT = 13,
    parameter int PPN_LSB  = 13
) (
    input  logic [XLEN-1:0]  va,
    input  logic [LVL_W-1:0] lvl,
    input  logic [XLEN-1:0]  raw,
    input  logic [XLEN-1:0]  mem_size,
    output logic [XLEN-1:0]  merged,
    output logic             fits
);
    localparam logic [XLEN-1:0] OFS_MASK = (XLEN'(1) << PG_SHIFT) - XLEN'(1);

    logic [XLEN-1:0] low_mask;
    logic [XLEN-1:0] phys;

    always_comb begin
        low_mask = (XLEN'(1) << (int'(lvl) * IDX_W)) - XLEN'(1);
        merged   = raw | (((va >> PG_SHIFT) & low_mask) << PPN_LSB);
        phys     = ((merged >> PPN_LSB) << PG_SHIFT) + (va & OFS_MASK);
        fits     = phys < mem_size;
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
    parameter int XLEN      = 64,
    parameter int VA_W      = 43,
    parameter int LEVELS    = 3,
    parameter int IDX_W     = 10,
    parameter int PG_SHIFT  = 13,
    parameter int PPN_LSB   = 13,
    parameter int PTE_BYTES = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [XLEN-1:0] vaddr,
    input  logic            vm_en,
    input  logic [XLEN-1:0] ptbr,
    input  logic [XLEN-1:0] mem_size,
    output logic            busy,
    output logic            done,
    output logic [XLEN-1:0] pte,
    output logic            mem_req,
    output logic [XLEN-1:0] mem_addr,
    input  logic            mem_rvalid,
    input  logic [XLEN-1:0] mem_rdata
);
    import ptw_pkg::*;

    localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;
    localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(LEVELS - 1);
    localparam logic [XLEN-1:0] IDENT_FLAGS = XLEN'(PERM_ALL) | (XLEN'(1) << LEAF_BIT);

    typedef struct packed {
        walk_state_e     st;
        logic [LVL_W-1:0] lvl;
        logic [XLEN-1:0] va;
        logic [XLEN-1:0] base;
        logic [XLEN-1:0] res;
        logic            done;
        logic            req;
        logic [XLEN-1:0] addr;
    } walk_t;

    walk_t w_q, w_d;

    logic            canon_ok;
    logic [XLEN-1:0] ent_addr;
    logic            ent_in_mem;
    logic [XLEN-1:0] leaf_pte;
    logic            leaf_fits;

    ptw_canon #(.XLEN(XLEN), .VA_W(VA_W)) u_canon (
        .va (vaddr),
        .ok (canon_ok)
    );

    ptw_index #(
        .XLEN(XLEN), .LVL_W(LVL_W), .IDX_W(IDX_W),
        .PG_SHIFT(PG_SHIFT), .PTE_BYTES(PTE_BYTES)
    ) u_index (
        .va       (w_q.va),
        .base     (w_q.base),
        .lvl      (w_q.lvl),
        .mem_size (mem_size),
        .ent_addr (ent_addr),
        .in_mem   (ent_in_mem)
    );

    ptw_leaf #(
        .XLEN(XLEN), .LVL_W(LVL_W), .IDX_W(IDX_W),
        .PG_SHIFT(PG_SHIFT), .PPN_LSB(PPN_LSB)
    ) u_leaf (
        .va       (w_q.va),
        .lvl      (w_q.lvl),
        .raw      (mem_rdata),
        .mem_size (mem_size),
        .merged   (leaf_pte),
        .fits     (leaf_fits)
    );

    always_comb begin
        w_d      = w_q;
        w_d.done = 1'b0;
        w_d.req  = 1'b0;
        unique case (w_q.st)
            W_IDLE: begin
                if (start) begin
                    w_d.va  = vaddr;
                    w_d.res = '0;
                    if (!canon_ok) begin
                        w_d.done = 1'b1;
                    end else if (!vm_en) begin
                        w_d.done = 1'b1;
                        if (vaddr < mem_size)
                            w_d.res = IDENT_FLAGS | ((vaddr >> PG_SHIFT) << PPN_LSB);
                    end else begin
                        w_d.st   = W_REQ;
                        w_d.base = ptbr;
                        w_d.lvl  = TOP_LVL;
                    end
                end
            end
            W_REQ: begin
                if (!ent_in_mem) begin
                    w_d.done = 1'b1;
                    w_d.res  = '0;
                    w_d.st   = W_IDLE;
                end else begin
                    w_d.req  = 1'b1;
                    w_d.addr = ent_addr;
                    w_d.st   = W_WAIT;
                end
            end
            W_WAIT: begin
                if (mem_rvalid) begin
                    if (mem_rdata[LEAF_BIT]) begin
                        w_d.done = 1'b1;
                        w_d.res  = leaf_fits ? leaf_pte : '0;
                        w_d.st   = W_IDLE;
                    end else if (!mem_rdata[TBL_BIT] || (w_q.lvl == '0)) begin
                        w_d.done = 1'b1;
                        w_d.res  = '0;
                        w_d.st   = W_IDLE;
                    end else begin
                        w_d.base = (mem_rdata >> PPN_LSB) << PG_SHIFT;
                        w_d.lvl  = w_q.lvl - LVL_W'(1);
                        w_d.st   = W_REQ;
                    end
                end
            end
            default: w_d.st = W_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q <= '{st: W_IDLE, lvl: '0, va: '0, base: '0, res: '0,
                     done: 1'b0, req: 1'b0, addr: '0};
        end else begin
            w_q <= w_d;
        end
    end

    assign busy     = (w_q.st != W_IDLE);
    assign done     = w_q.done;
    assign pte      = w_q.res;
    assign mem_req  = w_q.req;
    assign mem_addr = w_q.addr;

    // R9
    single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R9
    req_in_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy && !done);

    // R1
    noncanon_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !((&vaddr[XLEN-1:VA_W-1]) || !(|vaddr[XLEN-1:VA_W-1])))
        |=> (done && (pte == '0) && !busy && !mem_req));

    // R2
    bare_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !vm_en && (vaddr >= mem_size))
        |=> (done && (pte == '0) && !busy));

    // R5
    leaf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (pte != '0)) |-> pte[LEAF_BIT]);
endmodule

// File: tb/ptw_walker_test.sv
module ptw_walker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] vaddr = '0;
    logic        vm_en = 1'b0;
    logic [63:0] ptbr = '0;
    logic [63:0] mem_size = 64'h10_0000;
    logic        busy, done, mem_req;
    logic [63:0] pte, mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [63:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;
    int reads = 0;

    logic [63:0] words [logic [63:0]];

    always #5 clk = ~clk;

    ptw_walker uut (
        .clk(clk), .rst_n(rst_n), .start(start), .vaddr(vaddr), .vm_en(vm_en),
        .ptbr(ptbr), .mem_size(mem_size), .busy(busy), .done(done), .pte(pte),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata)
    );

    // memory responder with a random 0..2 cycle extra latency
    logic        pend = 1'b0;
    logic [63:0] paddr = '0;
    int          dly = 0;
    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (pend) begin
            if (dly == 0) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= words.exists(paddr) ? words[paddr] : 64'd0;
                pend       <= 1'b0;
            end else begin
                dly <= dly - 1;
            end
        end
        if (mem_req) begin
            pend  <= 1'b1;
            paddr <= mem_addr;
            dly   <= int'($urandom_range(0, 2));
            reads <= reads + 1;
        end
    end

    function automatic logic [63:0] rd(input logic [63:0] a);
        return words.exists(a) ? words[a] : 64'd0;
    endfunction

    // reference walk computed from the requirements
    function automatic void model(input logic [63:0] va, input logic vm,
                                  input logic [63:0] root, input logic [63:0] ms,
                                  output logic [63:0] res, output int nrd);
        logic [63:0] b, d, ix, pa, ppn;
        res = '0;
        nrd = 0;
        if ({{21{va[42]}}, va[42:0]} != va) return;
        if (!vm) begin
            if (va < ms) res = 64'hFE | ((va >> 13) << 13);
            return;
        end
        b = root;
        for (int lv = 2; lv >= 0; lv--) begin
            ix = (va >> (13 + lv * 10)) & 64'h3FF;
            pa = b + ix * 8;
            if (pa >= ms) return;
            nrd++;
            d = rd(pa);
            if (d[1]) begin
                d = d | (((va >> 13) & ((64'd1 << (lv * 10)) - 1)) << 13);
                ppn = d >> 13;
                if ((ppn << 13) + (va & 64'h1FFF) < ms) res = d;
                return;
            end
            if (!d[0]) return;
            b = (d >> 13) << 13;
        end
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // launches at a falling edge, returns at the falling edge showing done
    task automatic walk(input logic [63:0] va, input logic vm, input logic [63:0] root,
                        output logic [63:0] res, output int nrd);
        int n = 0;
        int r0;
        r0    = reads;
        vaddr = va;
        vm_en = vm;
        ptbr  = root;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && n < 100) begin
            @(negedge clk);
            n++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R10 watchdog actual=no_done expected=done");
        end
        res = pte;
        nrd = reads - r0;
    endtask

    task automatic run_cmp(input string tag, input logic [63:0] va, input logic vm,
                           input logic [63:0] root, input logic [63:0] exp_lit,
                           input int exp_rd);
        logic [63:0] got, mexp;
        int nrd, mrd;
        model(va, vm, root, mem_size, mexp, mrd);
        walk(va, vm, root, got, nrd);
        chk(tag, got, exp_lit);
        chk({tag, " R9 reads"}, 64'(nrd), 64'(exp_rd));
        chk({tag, " model"}, mexp, exp_lit);
    endtask

    localparam logic [63:0] VA0 = 64'h0003_4567;

    initial begin
        logic [63:0] got, exp;
        int nrd, mrd;
        void'($urandom(32'd1234));

        repeat (3) @(negedge clk);
        chk("R11 busy", {63'd0, busy}, 64'd0);
        chk("R11 done", {63'd0, done}, 64'd0);
        chk("R11 mem_req", {63'd0, mem_req}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: bit 43 set, bit 42 clear
        run_cmp("R1 noncanon", 64'h0000_0800_0000_0000, 1'b1, 64'h2000, 64'd0, 0);
        // R2 identity and out of range
        run_cmp("R2 bare in", 64'h12345, 1'b0, 64'h2000, 64'h120FE, 0);
        run_cmp("R2 bare edge", 64'h10_0000, 1'b0, 64'h2000, 64'd0, 0);
        // R10: with no new start, done drops after one cycle
        @(negedge clk);
        chk("R10 done width", {63'd0, done}, 64'd0);

        // R5: top-level superpage leaf
        words.delete();
        words[64'h2000] = 64'hFE;
        run_cmp("R5 top leaf", VA0, 1'b1, 64'h2000, 64'h340FE, 1);

        // R3 R7: full three-level walk
        words.delete();
        words[64'h2000] = (64'd5 << 13) | 64'd1;
        words[64'hA000] = (64'd6 << 13) | 64'd1;
        words[64'hC0D0] = (64'h40 << 13) | 64'h0E;
        run_cmp("R3 R7 three level", VA0, 1'b1, 64'h2000, 64'h8000E, 3);

        // R6: leaf past memory end
        words[64'hC0D0] = (64'h80 << 13) | 64'h2;
        run_cmp("R6 leaf bound", VA0, 1'b1, 64'h2000, 64'd0, 3);

        // R8: table bit at the last level
        words[64'hC0D0] = (64'd7 << 13) | 64'd1;
        run_cmp("R8 exhausted", VA0, 1'b1, 64'h2000, 64'd0, 3);

        // R5: middle-level superpage merge
        words[64'hA000] = (64'h40 << 13) | 64'hFE;
        run_cmp("R5 mid leaf", VA0, 1'b1, 64'h2000, 64'hB40FE, 2);

        // R7: neither leaf nor table
        words[64'hA000] = 64'hFC;
        run_cmp("R7 invalid", VA0, 1'b1, 64'h2000, 64'd0, 2);

        // R4: next table beyond memory, and root beyond memory
        words[64'hA000] = (64'h90 << 13) | 64'd1;
        run_cmp("R4 table past end", VA0, 1'b1, 64'h2000, 64'd0, 2);
        run_cmp("R4 root past end", VA0, 1'b1, 64'h10_0000, 64'd0, 0);

        // random walks, each launched in the done cycle of the previous one
        for (int t = 0; t < 400; t++) begin
            logic [63:0] va, b, root, pa, ix, ppn;
            logic vm;
            int kind;
            words.delete();
            va = {$urandom, $urandom};
            va = {{21{va[42]}}, va[42:0]};
            if ($urandom_range(0, 7) == 0) va[50] = ~va[50];
            if ($urandom_range(0, 3) == 0) va = 64'($urandom_range(0, 32'h20_0000));
            vm = ($urandom_range(0, 3) != 0);
            root = 64'($urandom_range(0, 130)) << 13;
            b = root;
            for (int lv = 2; lv >= 0; lv--) begin
                ix = (va >> (13 + lv * 10)) & 64'h3FF;
                pa = b + ix * 8;
                kind = int'($urandom_range(0, 7));
                ppn = 64'($urandom_range(0, 131));
                if (kind < 3)
                    words[pa] = (ppn << 13) | 64'h2 | (64'($urandom_range(0, 63)) << 2);
                else if (kind < 7) begin
                    words[pa] = (ppn << 13) | 64'h1;
                    b = ppn << 13;
                end else
                    words[pa] = 64'($urandom_range(0, 63)) << 2;
            end
            model(va, vm, root, mem_size, exp, mrd);
            walk(va, vm, root, got, nrd);
            chk("R3 R5 R6 R7 random result", got, exp);
            chk("R9 random reads", 64'(nrd), 64'(mrd));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        checks++;
        errors++;
        $display("FAIL R10 global watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule